// File: doc/BRIEF.md
# Signed Fixed-Point to Decimal Text Formatter

The block turns one signed fixed-point number into a string of ASCII characters for a character display or any other byte consumer. The number arrives as a sign flag plus an unsigned magnitude whose lowest `FRAC_W` bits are the fraction. A one-cycle `start` captures the operand. The block first converts the integer part to packed BCD with a sequential shift-and-add-3 loop. It then streams the text one byte at a time: an optional minus sign, the integer digits, a decimal point, and the fractional digits.

Fraction digits are produced by multiplying the remaining fraction by ten and taking the four bits that overflow above the binary point. With `FRAC_W` digits the decimal text is the exact value of the binary fraction. Every byte goes out through a valid/ready handshake and stays put until it is accepted. A one-cycle `done` pulse marks the end of the string.

Top module: `fxp_ascii_fmt`

## Requirements
- R1: After reset `out_valid`, `busy` and `done` are low, and `out_valid` is never high while `busy` is low.
- R2: The first byte is a minus sign (0x2D) if and only if `sign_in` was set and the captured magnitude is nonzero. A negative zero prints without a sign.
- R3: The integer part (magnitude bits above the binary point) is printed in decimal, most significant digit first, with leading zeros suppressed. An integer part of zero prints as the single digit '0'.
- R4: Every digit byte is 0x30 plus the digit value 0 to 9, so every emitted byte is a digit, 0x2D or 0x2E.
- R5: A decimal point (0x2E) follows the last integer digit and comes before any fraction digit.
- R6: Exactly `FRAC_W` fraction digits follow the point, including trailing zeros, and they give the exact decimal value of the fraction bits.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_char` does not change.
- R8: A `start` pulse while `busy` is high is ignored: it neither changes the string in progress nor begins another one.
- R9: `done` is high for exactly one cycle, after the last fraction digit has been accepted and while `out_valid` is low; `busy` falls on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Capture the operand and begin (ignored while busy) |
| sign_in | input | 1 | Sign of the value, 1 = negative |
| mag_in | input | INT_W+FRAC_W | Unsigned magnitude, lowest FRAC_W bits are the fraction |
| busy | output | 1 | A conversion or output string is in progress |
| out_valid | output | 1 | `out_char` holds a byte to be taken |
| out_ready | input | 1 | Consumer accepts the byte this cycle |
| out_char | output | 8 | ASCII byte |
| done | output | 1 | One-cycle pulse after the last byte |

## Verification
The hardest case to reach from the ports is a second `start` that lands while a string is still being shifted out under back-pressure. It must be seen to change nothing. The bench fires extra start pulses with a different operand in the middle of a run while ready is throttled by a pseudo-random pattern. It then requires that only the first operand's text arrives and that exactly one `done` appears for it. The digit corner cases are driven as explicit operands: negative zero, the full-scale magnitude, the smallest fraction step, and integers with inner zeros.

// File: rtl/fxp_ascii_fmt.sv
module fxp_ascii_fmt #(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    sign_in,
  input  logic [INT_W+FRAC_W-1:0] mag_in,
  output logic                    busy,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [7:0]              out_char,
  output logic                    done
);
  localparam int ND    = (INT_W * 30103) / 100000 + 1;
  localparam int BCD_W = 4 * ND;
  localparam int IW    = $clog2(ND + 1);
  localparam int MAXW  = (INT_W > FRAC_W) ? INT_W : FRAC_W;
  localparam int CW    = $clog2(MAXW + 1);
  localparam int PW    = FRAC_W + 4;

  typedef enum logic [2:0] {S_IDLE, S_DAB, S_PREP, S_SIGN, S_INT, S_POINT, S_FRAC, S_DONE} st_t;

  st_t               st;
  logic [INT_W-1:0]  ish;
  logic [BCD_W-1:0]  bcd, bcd_adj;
  logic [FRAC_W-1:0] frac;
  logic [CW-1:0]     cnt;
  logic [IW-1:0]     idx, lead;
  logic              neg;
  logic [3:0]        cur_dig;
  logic [PW-1:0]     prod;
  logic              take;

  always_comb begin
    for (int i = 0; i < ND; i++)
      bcd_adj[4*i +: 4] = (bcd[4*i +: 4] >= 4'd5) ? bcd[4*i +: 4] + 4'd3 : bcd[4*i +: 4];
  end

  always_comb begin
    lead = '0;
    for (int i = 0; i < ND; i++)
      if (bcd[4*i +: 4] != 4'd0) lead = IW'(i);
  end

  assign cur_dig = 4'(bcd >> {idx, 2'b00});
  assign prod    = {4'b0, frac} * PW'(10);
  assign busy      = (st != S_IDLE);
  assign done      = (st == S_DONE);
  assign out_valid = (st == S_SIGN) || (st == S_INT) || (st == S_POINT) || (st == S_FRAC);
  assign take      = out_valid && out_ready;

  always_comb begin
    case (st)
      S_SIGN:  out_char = 8'h2D;
      S_INT:   out_char = {4'h3, cur_dig};
      S_POINT: out_char = 8'h2E;
      S_FRAC:  out_char = {4'h3, prod[PW-1:FRAC_W]};
      default: out_char = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      ish  <= '0;
      bcd  <= '0;
      frac <= '0;
      cnt  <= '0;
      idx  <= '0;
      neg  <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          neg  <= sign_in && (mag_in != '0);
          ish  <= mag_in[INT_W+FRAC_W-1:FRAC_W];
          frac <= mag_in[FRAC_W-1:0];
          bcd  <= '0;
          cnt  <= '0;
          st   <= S_DAB;
        end
        S_DAB: begin
          bcd <= {bcd_adj[BCD_W-2:0], ish[INT_W-1]};
          ish <= ish << 1;
          cnt <= cnt + 1'b1;
          if (cnt == CW'(INT_W - 1)) st <= S_PREP;
        end
        S_PREP: begin
          idx <= lead;
          cnt <= '0;
          st  <= neg ? S_SIGN : S_INT;
        end
        S_SIGN: if (take) st <= S_INT;
        S_INT: if (take) begin
          if (idx == '0) st <= S_POINT;
          else idx <= idx - 1'b1;
        end
        S_POINT: if (take) st <= S_FRAC;
        S_FRAC: if (take) begin
          frac <= prod[FRAC_W-1:0];
          cnt  <= cnt + 1'b1;
          if (cnt == CW'(FRAC_W - 1)) st <= S_DONE;
        end
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fxp_ascii_fmt_chk.sv
module fxp_ascii_fmt_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_char,
  input logic       done
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!out_valid && !done)); // R1
  AST_CHAR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_char >= 8'h30 && out_char <= 8'h39) || out_char == 8'h2D || out_char == 8'h2E)); // R4
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_char))); // R7
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !done) |=> busy); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy)); // R9
  AST_DONE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !out_valid); // R9
endmodule

bind fxp_ascii_fmt fxp_ascii_fmt_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .out_valid(out_valid),
  .out_ready(out_ready), .out_char(out_char), .done(done)
);

// File: tb/tb_fxp_ascii_fmt.sv
module tb_fxp_ascii_fmt;
  localparam int INT_W = 16;
  localparam int FRAC_W = 16;

  logic clk = 0, rst_n = 0, start = 0, sign_in = 0, out_ready = 0;
  logic [INT_W+FRAC_W-1:0] mag_in = '0;
  logic busy, out_valid, done;
  logic [7:0] out_char;

  int errors = 0, checks = 0, cycles = 0, dones = 0, runs = 0;
  byte   exp_q[$];
  string req_q[$];
  logic [7:0] lfsr = 8'h5A;
  logic hold_pend = 0;
  logic [7:0] hold_char;
  bit throttle = 0;

  always #4 clk = ~clk;

  fxp_ascii_fmt #(.INT_W(INT_W), .FRAC_W(FRAC_W)) dut (.*);

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push_expected(bit s, logic [31:0] m);
    string ds;
    longint f;
    if (s && m != 0) begin exp_q.push_back(8'h2D); req_q.push_back("R2 sign"); end
    ds = $sformatf("%0d", m[31:16]);
    for (int i = 0; i < ds.len(); i++) begin
      exp_q.push_back(ds[i]); req_q.push_back("R3 integer digit");
    end
    exp_q.push_back(8'h2E); req_q.push_back("R5 point");
    f = longint'(m[15:0]);
    for (int i = 0; i < FRAC_W; i++) begin
      f = f * 10;
      exp_q.push_back(byte'(8'h30 + (f >> 16))); req_q.push_back("R6 fraction digit");
      f = f & 64'hFFFF;
    end
    runs++;
  endtask

  task automatic launch(bit s, logic [31:0] m);
    @(negedge clk);
    while (busy) @(negedge clk);
    push_expected(s, m);
    sign_in = s; mag_in = m; start = 1;
    @(negedge clk);
    start = 0; sign_in = 0; mag_in = '0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run(bit s, logic [31:0] m);
    launch(s, m);
    wait_done();
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      cycles++;
      if (rst_n) begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        out_ready = throttle ? (lfsr[0] & lfsr[1]) : (lfsr[0] | lfsr[1]);
        if (hold_pend) begin
          chk(out_valid && out_char == hold_char, "R7", "held byte", out_char, hold_char);
          hold_pend = 0;
        end
        if (out_valid && !out_ready) begin hold_pend = 1; hold_char = out_char; end
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) chk(0, "R8", "unexpected byte", out_char, 0);
          else begin
            byte e; string r;
            e = exp_q.pop_front(); r = req_q.pop_front();
            chk(out_char == e, r, "byte", out_char, e);
          end
        end
        if (done) begin
          dones++;
          chk(exp_q.size() == 0 && !out_valid, "R9", "done after last byte", exp_q.size(), 0);
        end
      end
    end
  end

  initial begin
    wait (cycles > 150000);
    chk(0, "WDOG", "watchdog expired", cycles, 150000);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!out_valid && !busy && !done, "R1", "reset outputs", {busy, out_valid, done}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!out_valid && !busy && !done, "R1", "idle after reset", {busy, out_valid, done}, 0);

    run(1'b1, 32'h0000_0000);   // R2 negative zero, R3 single '0'
    run(1'b1, 32'h0001_8000);   // -1.5
    run(1'b0, 32'hFFFF_FFFF);   // full scale
    run(1'b0, 32'h0000_0001);   // smallest step, R6 exact
    run(1'b0, 32'h0064_4000);   // 100.25, inner zeros R3
    run(1'b1, 32'h2710_0000);   // -10000
    throttle = 1;
    run(1'b0, 32'h3039_1234);   // R7 heavy back-pressure
    // R8: extra starts during a busy run
    launch(1'b1, 32'h0007_C000);
    repeat (5) @(negedge clk);
    sign_in = 0; mag_in = 32'h0999_0001; start = 1;
    @(negedge clk); start = 0;
    repeat (20) @(negedge clk);
    start = 1; @(negedge clk); start = 0;
    wait_done();
    throttle = 0;
    repeat (40) @(negedge clk);
    chk(!busy && exp_q.size() == 0, "R8", "no extra string", exp_q.size(), 0);
    chk(dones == runs, "R9", "one done per run", dones, runs);
    chk(!out_valid, "R1", "idle valid low", out_valid, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule